// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a translation table held in memory. The walk starts at a context table entry chosen by the current context number. It then follows pointer entries through at most three directory levels. It stops at the first page entry it meets. A page entry found at the first, second or third level maps a 16 MB, 256 KB or 4 KB page. When the walk ends at a valid page, the walker sets the entry's referenced bit. It also sets the modified bit when the access is a store. The entry is written back to memory only when one of those bits actually changes.

A requester hands over one address at a time with a valid/ready handshake. Each result comes back with a one-cycle `done` pulse. The result is either a successful mapping (entry, page size, physical address) or a fault code. The fault code encodes the level where the walk stopped and the reason. Memory is reached through a single request/response port that carries 32-bit words. When translation is switched off, addresses pass straight through with unrestricted access. In boot mode, instruction fetches in that state are steered into a boot ROM window.

Top module: `ptw_top`

## Requirements
- R1: `req_ready` is high only while no walk is in progress, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each request yields exactly one `done` pulse, one cycle long.
- R2: The first read of a walk is at byte address `cfg_ctx_base*16 + cfg_ctx*4`.
- R3: The low two bits of each fetched word select its kind: 0 invalid, 1 pointer, 2 page, 3 reserved. After a pointer, the next read is at `(word with bits 1:0 cleared)*16 + 4*index`. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: A fault ends the walk with `res_ok`=0 and `res_fault = level*256 + kind*4`. The kind is 1 for an invalid word and 4 for a reserved word. A page word at level 0 and a pointer word at level 3 also give kind 4. The context entry counts as level 0.
- R5: A page word at level 1, 2 or 3 gives `res_size` 2 (16 MB), 1 (256 KB) or 0 (4 KB). The page offset is taken from VA[23:0], VA[17:0] or VA[11:0] respectively.
- R6: On success, `res_pa = (word bits 31:8)*4096 + page offset`.
- R7: On success, `res_entry` is the page word with bit 5 (referenced) set, and with bit 6 (modified) set as well for a store. A single write of that value goes to the page word's address only when it differs from the fetched word.
- R8: With `cfg_enable` low, a request completes with `done` on its acceptance edge. It gives `res_ok`=1, `res_bypass`=1, `res_size`=0, `res_pa` = the zero-extended VA, and it makes no memory access.
- R9: With `cfg_enable` low and `cfg_boot` high, an instruction fetch (`req_fetch`=1) returns `res_pa = cfg_prom_base | VA[18:0]`. Other accesses are not redirected.
- R10: A response with `mem_rsp_err` high ends the walk with `res_ok`=0 and `res_fault = level*256 + 8`.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and direction hold.
- R12: Every memory access costs two cycles against a memory that is always ready and answers on the following cycle. `done` therefore rises 2*(reads+writes) cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Translation on |
| cfg_boot | input | 1 | Boot mode: fetches go to ROM window when translation is off |
| cfg_ctx_base | input | 32 | Context table base (scaled by 16) |
| cfg_ctx | input | CTX_W | Current context number |
| cfg_prom_base | input | PA_W | Boot ROM base address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Memory request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | PA_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Response carries an error |
| done | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | Translation succeeded |
| res_bypass | output | 1 | Result came from the pass-through path |
| res_fault | output | 10 | Fault code: level in bits 9:8, kind in bits 4:2 |
| res_entry | output | 32 | Final page word including updated bits |
| res_pa | output | PA_W | Physical address |
| res_size | output | 2 | Page size: 0 4 KB, 1 256 KB, 2 16 MB |

## Verification
Against a memory that is always ready and answers one cycle after each accepted request, the walker adds no idle cycles. A pass-through result appears on the acceptance edge itself. A walk's `done` appears exactly two cycles per memory access later, and a write-back counts as one more access. After each acceptance the bench counts clock edges, sampling one nanosecond after every edge. It compares the count with the figure that its own model of the walk predicts, then checks the result fields on that same sample. It also checks that `done` has dropped one edge later. A run with a stalling memory drops the cycle count and checks only the values and the stability of held requests.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int FAULT_W   = 10;
  localparam int REF_BIT   = 5;
  localparam int MOD_BIT   = 6;
  localparam logic [1:0] LAST_LVL = 2'd3;

  localparam logic [1:0] ET_INVALID = 2'd0;
  localparam logic [1:0] ET_PTR     = 2'd1;
  localparam logic [1:0] ET_PAGE    = 2'd2;

  localparam logic [2:0] FK_INVALID  = 3'd1;
  localparam logic [2:0] FK_BUSERR   = 3'd2;
  localparam logic [2:0] FK_RESERVED = 3'd4;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_state_e;
  typedef enum logic [2:0] {OC_DESCEND, OC_LEAF, OC_WBDONE, OC_FAULT} outcome_e;

  function automatic logic [FAULT_W-1:0] fault_code(input logic [1:0] lvl,
                                                     input logic [2:0] kind);
    return {lvl, 3'b000, kind, 2'b00};
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen import ptw_pkg::*; #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic [1:0]       level,
  input  logic [31:0]      ctx_base,
  input  logic [CTX_W-1:0] ctx,
  input  logic [31:0]      entry,
  input  logic [31:0]      va,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] base;
  logic [PA_W-1:0] index;

  always_comb begin
    base = PA_W'({entry[31:2], 6'b0});
    unique case (level)
      2'd0: begin
        base  = PA_W'({ctx_base, 4'b0});
        index = PA_W'({ctx, 2'b00});
      end
      2'd1:    index = PA_W'({va[31:24], 2'b00});
      2'd2:    index = PA_W'({va[23:18], 2'b00});
      default: index = PA_W'({va[17:12], 2'b00});
    endcase
    addr = base + index;
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf import ptw_pkg::*; #(
  parameter int PA_W = 36
) (
  input  logic [31:0]     entry,
  input  logic [1:0]      level,
  input  logic [31:0]     va,
  input  logic            is_write,
  output logic [31:0]     new_entry,
  output logic            need_wb,
  output logic [PA_W-1:0] pa,
  output logic [1:0]      size
);
  logic [PA_W-1:0] offset;

  always_comb begin
    new_entry = entry | (32'd1 << REF_BIT);
    if (is_write) new_entry = new_entry | (32'd1 << MOD_BIT);
    need_wb = (new_entry != entry);
    unique case (level)
      2'd1: begin offset = PA_W'(va[23:0]); size = SZ_16M;  end
      2'd2: begin offset = PA_W'(va[17:0]); size = SZ_256K; end
      default: begin offset = PA_W'(va[11:0]); size = SZ_4K; end
    endcase
    pa = PA_W'({entry[31:8], 12'b0}) + offset;
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top import ptw_pkg::*; #(
  parameter int PA_W       = 36,
  parameter int CTX_W      = 8,
  parameter int BOOT_OFF_W = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_enable,
  input  logic               cfg_boot,
  input  logic [31:0]        cfg_ctx_base,
  input  logic [CTX_W-1:0]   cfg_ctx,
  input  logic [PA_W-1:0]    cfg_prom_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_va,
  input  logic               req_write,
  input  logic               req_fetch,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [31:0]        mem_req_wdata,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               done,
  output logic               res_ok,
  output logic               res_bypass,
  output logic [FAULT_W-1:0] res_fault,
  output logic [31:0]        res_entry,
  output logic [PA_W-1:0]    res_pa,
  output logic [1:0]         res_size
);
  walk_state_e     state_q;
  logic [1:0]      lvl_q;
  logic [31:0]     va_q;
  logic            wr_q;
  logic            wb_q;
  logic [PA_W-1:0] addr_q;
  logic [31:0]     wdata_q;

  logic [1:0]      gen_level;
  logic [31:0]     gen_va;
  logic [PA_W-1:0] gen_addr;
  logic [31:0]     leaf_entry;
  logic            leaf_wb;
  logic [PA_W-1:0] leaf_pa;
  logic [1:0]      leaf_size;
  outcome_e        oc;
  logic [2:0]      kind;
  logic            boot_hit;

  assign gen_level = (state_q == ST_IDLE) ? 2'd0 : lvl_q + 2'd1;
  assign gen_va    = (state_q == ST_IDLE) ? req_va : va_q;
  assign boot_hit  = cfg_boot && req_fetch;

  ptw_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
    .level(gen_level), .ctx_base(cfg_ctx_base), .ctx(cfg_ctx),
    .entry(mem_rsp_data), .va(gen_va), .addr(gen_addr)
  );

  ptw_leaf #(.PA_W(PA_W)) u_leaf (
    .entry(mem_rsp_data), .level(lvl_q), .va(va_q), .is_write(wr_q),
    .new_entry(leaf_entry), .need_wb(leaf_wb), .pa(leaf_pa), .size(leaf_size)
  );

  // Classify the response in the wait state.
  always_comb begin
    oc   = OC_FAULT;
    kind = FK_RESERVED;
    if (mem_rsp_err) begin
      kind = FK_BUSERR;
    end else if (wb_q) begin
      oc = OC_WBDONE;
    end else begin
      unique case (mem_rsp_data[1:0])
        ET_INVALID: kind = FK_INVALID;
        ET_PTR:     if (lvl_q != LAST_LVL) oc = OC_DESCEND;
        ET_PAGE:    if (lvl_q != 2'd0) oc = OC_LEAF;
        default:    kind = FK_RESERVED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lvl_q      <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      wb_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      done       <= 1'b0;
      res_ok     <= 1'b0;
      res_bypass <= 1'b0;
      res_fault  <= '0;
      res_entry  <= '0;
      res_pa     <= '0;
      res_size   <= SZ_4K;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q <= req_va;
          wr_q <= req_write;
          if (!cfg_enable) begin
            done       <= 1'b1;
            res_ok     <= 1'b1;
            res_bypass <= 1'b1;
            res_fault  <= '0;
            res_entry  <= '0;
            res_size   <= SZ_4K;
            res_pa     <= boot_hit ? (cfg_prom_base | PA_W'(req_va[BOOT_OFF_W-1:0]))
                                   : PA_W'(req_va);
          end else begin
            lvl_q      <= 2'd0;
            wb_q       <= 1'b0;
            addr_q     <= gen_addr;
            res_bypass <= 1'b0;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          unique case (oc)
            OC_DESCEND: begin
              lvl_q   <= lvl_q + 2'd1;
              addr_q  <= gen_addr;
              state_q <= ST_ISSUE;
            end
            OC_LEAF: begin
              res_entry <= leaf_entry;
              res_pa    <= leaf_pa;
              res_size  <= leaf_size;
              res_fault <= '0;
              if (leaf_wb) begin
                wb_q    <= 1'b1;
                wdata_q <= leaf_entry;
                state_q <= ST_ISSUE;
              end else begin
                done    <= 1'b1;
                res_ok  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
            OC_WBDONE: begin
              done    <= 1'b1;
              res_ok  <= 1'b1;
              state_q <= ST_IDLE;
            end
            default: begin
              done      <= 1'b1;
              res_ok    <= 1'b0;
              res_fault <= fault_code(lvl_q, kind);
              res_entry <= '0;
              res_pa    <= '0;
              res_size  <= SZ_4K;
              state_q   <= ST_IDLE;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_write = wb_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  a_r7_wb_has_ref: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[REF_BIT]);
  a_r4_fault_code_set: assert property (@(posedge clk) disable iff (rst)
    (done && !res_ok) |-> (res_fault != '0));
  a_r5_leaf_is_page: assert property (@(posedge clk) disable iff (rst)
    (done && res_ok && !res_bypass) |-> (res_entry[1:0] == ET_PAGE && res_entry[REF_BIT]));
  a_r8_bypass_small: assert property (@(posedge clk) disable iff (rst)
    (done && res_bypass) |-> (res_ok && res_size == SZ_4K));
endmodule

// File: tb/ptw_top_tb.sv
`timescale 1ns/1ps
module ptw_top_tb;
  localparam int PA_W  = 36;
  localparam int CTX_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cfg_enable = 1'b0, cfg_boot = 1'b0;
  logic [31:0] cfg_ctx_base = 32'h20;
  logic [CTX_W-1:0] cfg_ctx = '0;
  logic [PA_W-1:0] cfg_prom_base = 36'hF_FF80_0000;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_va = '0;
  logic req_ready;
  logic mem_req_valid, mem_req_write, mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done, res_ok, res_bypass;
  logic [9:0] res_fault;
  logic [31:0] res_entry;
  logic [PA_W-1:0] res_pa;
  logic [1:0] res_size;

  ptw_top #(.PA_W(PA_W), .CTX_W(CTX_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_boot(cfg_boot),
    .cfg_ctx_base(cfg_ctx_base), .cfg_ctx(cfg_ctx), .cfg_prom_base(cfg_prom_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_fetch(req_fetch),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .done(done), .res_ok(res_ok), .res_bypass(res_bypass), .res_fault(res_fault),
    .res_entry(res_entry), .res_pa(res_pa), .res_size(res_size)
  );

  // Memory model: 4096 words, single driver for the array.
  logic [31:0] mem [0:4095];
  logic stall_en = 1'b0, tick = 1'b0, err_en = 1'b0;
  logic [PA_W-1:0] err_addr = '0;
  logic tb_we = 1'b0, tb_clr = 1'b0;
  logic [11:0] tb_idx = '0;
  logic [31:0] tb_wd = '0;
  int acc_cnt = 0;
  logic [PA_W-1:0] first_addr = '0;
  logic first_seen = 1'b0;

  assign mem_req_ready = !stall_en || tick;

  always @(posedge clk) begin
    tick <= ~tick;
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (req_valid && req_ready) first_seen <= 1'b0;
    if (tb_clr) for (int i = 0; i < 4096; i++) mem[i] <= '0;
    if (tb_we) mem[tb_idx] <= tb_wd;
    if (mem_req_valid && mem_req_ready) begin
      acc_cnt       <= acc_cnt + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= err_en && (mem_req_addr == err_addr);
      mem_rsp_data  <= mem[mem_req_addr[13:2]];
      if (mem_req_write && !(err_en && mem_req_addr == err_addr))
        mem[mem_req_addr[13:2]] <= mem_req_wdata;
      if (!first_seen) begin
        first_addr <= mem_req_addr;
        first_seen <= 1'b1;
      end
    end
  end

  // R11 monitor: a stalled request must not change.
  int hold_viol = 0;
  logic hold_pend = 1'b0;
  logic [PA_W-1:0] hold_addr = '0;
  logic hold_wr = 1'b0;
  always @(negedge clk) begin
    if (hold_pend && (!mem_req_valid || mem_req_addr != hold_addr || mem_req_write != hold_wr))
      hold_viol++;
    hold_pend = mem_req_valid && !mem_req_ready && !rst;
    hold_addr = mem_req_addr;
    hold_wr   = mem_req_write;
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [PA_W-1:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = byte_addr[13:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [PA_W-1:0] lvl_addr(input logic [31:0] va, input int lv);
    case (lv)
      0: return PA_W'({cfg_ctx_base, 4'b0}) + PA_W'({cfg_ctx, 2'b00});
      1: return PA_W'(32'h1000) + PA_W'({va[31:24], 2'b00});
      2: return PA_W'(32'h2000) + PA_W'({va[23:18], 2'b00});
      default: return PA_W'(32'h3000) + PA_W'({va[17:12], 2'b00});
    endcase
  endfunction

  function automatic logic [31:0] next_ptr(input int lv);
    return (lv == 0) ? 32'h101 : (lv == 1) ? 32'h201 : 32'h301;
  endfunction

  // Reference walk computed from the requirements over the model memory.
  task automatic model(input logic [31:0] va, input logic wr,
                       output logic ok, output logic [9:0] fc, output logic [31:0] ent,
                       output logic [PA_W-1:0] pa, output logic [1:0] sz,
                       output int acc, output logic [PA_W-1:0] leaf);
    logic [PA_W-1:0] a;
    logic [31:0] e;
    int lv;
    bit fin;
    a = PA_W'({cfg_ctx_base, 4'b0}) + PA_W'(cfg_ctx) * 4;
    lv = 0; acc = 0; ok = 0; fc = '0; ent = '0; pa = '0; sz = 2'd0; leaf = '0; fin = 0;
    while (!fin) begin
      acc++;
      e = mem[a[13:2]];
      if (err_en && a == err_addr) begin fc = 10'(lv*256 + 8); fin = 1; end
      else if (e[1:0] == 2'd0) begin fc = 10'(lv*256 + 4); fin = 1; end
      else if (e[1:0] == 2'd3) begin fc = 10'(lv*256 + 16); fin = 1; end
      else if (e[1:0] == 2'd1) begin
        if (lv == 3) begin fc = 10'(lv*256 + 16); fin = 1; end
        else begin
          lv++;
          if (lv == 1) a = PA_W'({e[31:2], 6'b0}) + PA_W'(va[31:24]) * 4;
          else if (lv == 2) a = PA_W'({e[31:2], 6'b0}) + PA_W'(va[23:18]) * 4;
          else a = PA_W'({e[31:2], 6'b0}) + PA_W'(va[17:12]) * 4;
        end
      end else begin
        fin = 1;
        if (lv == 0) fc = 10'(16);
        else begin
          ok = 1; leaf = a;
          ent = e | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (ent != e) acc++;
          if (lv == 1) begin pa = PA_W'(e[31:8]) * 4096 + PA_W'(va[23:0]); sz = 2'd2; end
          else if (lv == 2) begin pa = PA_W'(e[31:8]) * 4096 + PA_W'(va[17:0]); sz = 2'd1; end
          else begin pa = PA_W'(e[31:8]) * 4096 + PA_W'(va[11:0]); sz = 2'd0; end
        end
      end
    end
  endtask

  // Issue one request; returns edges from acceptance to done.
  task automatic run(input logic [31:0] va, input logic wr, input logic fetch,
                     input int exp_lat, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; req_fetch = fetch;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R1 ready during walk", req_ready, exp_lat == 0);
    lat = 0;
    while (!done && lat < 1000) begin @(posedge clk); #1; lat++; end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input bit chk_lat,
                      input string ftag);
    logic ok; logic [9:0] fc; logic [31:0] ent; logic [PA_W-1:0] pa, leaf, a0;
    logic [1:0] sz; int acc, lat;
    a0 = PA_W'({cfg_ctx_base, 4'b0}) + PA_W'(cfg_ctx) * 4;
    model(va, wr, ok, fc, ent, pa, sz, acc, leaf);
    run(va, wr, 1'b0, 2*acc, lat);
    if (chk_lat) chk("R12 latency", lat, 2*acc);
    chk("R2 first read address", first_addr, a0);
    chk({ftag, " ok"}, res_ok, ok);
    chk({ftag, " fault code"}, res_fault, fc);
    chk("R8 not bypass", res_bypass, 1'b0);
    if (ok) begin
      chk("R6 physical address", res_pa, pa);
      chk("R5 page size", res_size, sz);
      chk("R7 result entry", res_entry, ent);
      chk("R7 memory image", mem[leaf[13:2]], ent);
    end
    @(posedge clk); #1;
    chk("R1 done one cycle", done, 1'b0);
  endtask

  task automatic build(input logic [31:0] va, input int stop, input int typ, input int salt);
    logic [31:0] w;
    for (int k = 0; k <= 3; k++) begin
      if (k < stop) w = next_ptr(k);
      else if (k == stop) begin
        if (typ == 1 && k < 3) w = next_ptr(k);
        else w = (32'(24'h0AB000 + salt) << 8) | 32'h1C | 32'(typ);
      end else w = 32'h0;
      poke(lvl_addr(va, k), w);
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ready", req_ready, 1'b1);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset no mem request", mem_req_valid, 1'b0);
    @(negedge clk); rst = 1'b0; tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;

    // R8 / R9: pass-through sweep
    cfg_enable = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        for (int v = 0; v < 3; v++) begin
          logic [31:0] va;
          logic [PA_W-1:0] exp_pa;
          int a_before;
          va = 32'h1357_9BDF + 32'(v) * 32'h2468_1011;
          cfg_boot = b[0];
          exp_pa = (b == 1 && f == 1) ? (cfg_prom_base | PA_W'(va[18:0])) : PA_W'(va);
          a_before = acc_cnt;
          run(va, v[0], f[0], 0, lat);
          chk("R8 bypass latency", lat, 0);
          chk("R8 bypass flag", res_bypass, 1'b1);
          chk("R8 bypass ok", res_ok, 1'b1);
          chk("R8 bypass size", res_size, 2'd0);
          chk("R9 bypass address", res_pa, exp_pa);
          @(posedge clk); #1;
          chk("R8 no memory access", acc_cnt - a_before, 0);
        end
    cfg_boot = 1'b0;
    cfg_enable = 1'b1;

    // R3/R4/R5/R6/R7: stop level x entry kind x direction
    for (int L = 0; L < 4; L++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < 2; w++) begin
          logic [31:0] va;
          va = {8'(8'h40 + L*16 + t*4 + w), 6'(L*11 + t + 1), 6'(t*13 + w*3 + 2),
                12'(12'h5A7 + L*t)};
          cfg_ctx = 8'(3 + L);
          build(va, L, t, L*16 + t);
          walk(va, w[0], 1'b1, "R4 R3 walk");
          if (t == 2 && L > 0) walk(va, w[0], 1'b1, "R7 repeat walk");
        end

    // R2: context sweep, only context 5 populated
    for (int c = 0; c < 8; c++) poke(PA_W'({cfg_ctx_base, 4'b0}) + PA_W'(c*4), 32'h0);
    cfg_ctx = 8'd5;
    build(32'hC3A5_6789, 2, 2, 7);
    for (int c = 0; c < 8; c++) begin
      cfg_ctx = 8'(c);
      walk(32'hC3A5_6789, 1'b0, 1'b1, "R2 context walk");
    end

    // R10: memory error at each level
    cfg_ctx = 8'd2;
    for (int L = 0; L < 4; L++) begin
      logic [31:0] va;
      va = 32'h7100_0000 + 32'(L) * 32'h0104_1000;
      build(va, 3, 2, 40 + L);
      err_en = 1'b1; err_addr = lvl_addr(va, L);
      walk(va, 1'b1, 1'b1, "R10 bus error");
      err_en = 1'b0;
    end

    // R11: stalling memory, full write walk
    stall_en = 1'b1;
    build(32'h9ABC_DEF0, 3, 2, 99);
    walk(32'h9ABC_DEF0, 1'b1, 1'b0, "R11 stalled walk");
    build(32'h0FED_CBA9, 1, 2, 98);
    walk(32'h0FED_CBA9, 1'b0, 1'b0, "R11 stalled walk");
    stall_en = 1'b0;
    chk("R11 held request stable", hold_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule